// File: doc/BRIEF.md
# Serial EEPROM Instruction Front-End

This block is the device side of a three-wire serial memory port, built around a 256-word by 16-bit register file. The pins are an active-low select, a serial clock and a data input. It drives a data output together with an output-enable, and the pair stands in for a tri-state pin. All pins are brought into a faster system clock and edge-detected there, so every decision is made synchronously.

The level of the serial clock at the moment select goes low decides the mode:
- **Clock high:** the block receives an instruction. An instruction is an 8-bit command, an 8-bit address and, for writes, 16 data bits. All fields are sent most significant bit first.
- **Clock low:** the block drives a ready/busy status bit.

Reads stream words out continuously. Writes are handed to a companion controller through a request/grant handshake. That controller owns program timing and write protection. It receives single-cycle enable and disable pulses, and it reports busy.

Top module: `eep_front`

## Requirements
- R1: When `sel_n` falls while `sclk` is high, the block receives an instruction and `sdout_en` stays 0. When `sel_n` falls while `sclk` is low, status mode is entered and `sdout_en` becomes 1.
- R2: Bits on `sdin` are taken on rising `sclk` edges, MSB first, in this order: command byte, address byte, 16 data bits. Command codes are: read 8'b10101000, write 8'b10100100, enable 8'b10100011, disable 8'b10100000. After the 32nd rising edge of a write, `wr_req` rises with `wr_addr` equal to the address byte and `wr_data` equal to the data bits.
- R3: For a read, `sdout_en` stays 0 through the 16th rising edge. On the 17th falling `sclk` edge it becomes 1 and shows bit 15 of the addressed word. Each later falling edge presents the next lower bit.
- R4: If clocking continues past 16 read bits, the next word follows at address+1, and address 255 is followed by address 0.
- R5: Raising `sel_n` before an instruction completes abandons it: no request and no pulse are issued. `sdout_en` is 0 whenever the block is neither reading nor in status mode, including right after `sel_n` rises.
- R6: In status mode `sdout` equals the inverse of `wr_busy` and follows it. A rising `sclk` edge with `sdout_en`... with `sdin`=0 leaves status mode in place. A rising edge with `sdin`=1 ends status mode, sets `sdout_en` to 0, and counts that bit as the first command bit.
- R7: After the 16th rising edge of an enable or disable command, `wen_pulse` or `wdis_pulse` is high for exactly one cycle, whatever the address byte holds. The two are never high together.
- R8: Any other command code, including 8'b10101111, is ignored until `sel_n` rises: no pulse, no request, and `sdout_en` stays 0 even while clocking continues.
- R9: When `wr_busy` is 1 as `sel_n` falls with `sclk` high, the instruction that follows is ignored, as in R8.
- R10: `wr_req`, `wr_addr` and `wr_data` hold steady until `wr_gnt` or `wr_deny` is seen, and `wr_req` is 0 the cycle after. A grant stores the word, so a later read returns it. A deny leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| sdout_en | output | 1 | Drive enable for `sdout` (0 = high impedance) |
| wr_req | output | 1 | Write request to the companion controller |
| wr_addr | output | 8 | Word address of the pending write |
| wr_data | output | 16 | Data of the pending write |
| wr_gnt | input | 1 | Companion accepts the write; word is stored |
| wr_deny | input | 1 | Companion refuses the write |
| wr_busy | input | 1 | Companion is programming |
| wen_pulse | output | 1 | One-cycle write-enable command |
| wdis_pulse | output | 1 | One-cycle write-disable command |

## Verification
The hardest situation to reach from the ports is the hand-over from status mode into instruction reception. The first command bit is consumed by the same edge that ends the status display, so an off-by-one in the bit counter shows up only as a misread address much later. The stimulus therefore enters status mode with the clock low and toggles busy to see the display follow it. It first clocks a 0 that must not end status mode, then a 1 that must. It finishes the read opcode from its second bit and compares the streamed word against the bench model. Address wraparound is reached by starting a read at word 255 and clocking twenty bits.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_READ  = 8'b1010_1000;
    localparam logic [OP_W-1:0] OPC_WRITE = 8'b1010_0100;
    localparam logic [OP_W-1:0] OPC_WEN   = 8'b1010_0011;
    localparam logic [OP_W-1:0] OPC_WDIS  = 8'b1010_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_READ,
        ST_STAT,
        ST_HOLD,
        ST_WREQ
    } state_e;

    typedef enum logic [2:0] {
        CMD_BAD,
        CMD_READ,
        CMD_WRITE,
        CMD_WEN,
        CMD_WDIS
    } cmd_e;

    typedef struct packed {
        logic sel_lvl;
        logic sel_fall;
        logic sel_rise;
        logic sk_lvl;
        logic sk_rise;
        logic sk_fall;
        logic din;
    } pin_evt_t;

    function automatic cmd_e decode_op(input logic [OP_W-1:0] op);
        case (op)
            OPC_READ:  return CMD_READ;
            OPC_WRITE: return CMD_WRITE;
            OPC_WEN:   return CMD_WEN;
            OPC_WDIS:  return CMD_WDIS;
            default:   return CMD_BAD;
        endcase
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[i]}};
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_front.sv
module eep_front
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic              sdout,
    output logic              sdout_en,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_gnt,
    input  logic              wr_deny,
    input  logic              wr_busy,
    output logic              wen_pulse,
    output logic              wdis_pulse
);
    localparam int HDR   = OP_W + ADDR_W;
    localparam int FRAME = HDR + DATA_W;
    localparam int CW    = $clog2(FRAME + 1);
    localparam int BW    = $clog2(DATA_W);
    localparam int SH_W  = ADDR_W + DATA_W;

    localparam logic [CW-1:0] CNT_OP  = CW'(OP_W);
    localparam logic [CW-1:0] CNT_HDR = CW'(HDR);
    localparam logic [CW-1:0] CNT_FRM = CW'(FRAME);
    localparam logic [BW-1:0] IDX_TOP = BW'(DATA_W - 1);

    // pin synchronisation: {sdin, sclk, sel_n}
    logic [2:0] pin_q;
    logic [1:0] ctl_prev;
    pin_evt_t   ev;

    eep_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdin, sclk, sel_n}),
        .q   (pin_q)
    );

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= 2'b01;
        else     ctl_prev <= pin_q[1:0];
    end

    always_comb begin
        ev.sel_lvl  = pin_q[0];
        ev.sel_fall = ctl_prev[0] & ~pin_q[0];
        ev.sel_rise = ~ctl_prev[0] & pin_q[0];
        ev.sk_lvl   = pin_q[1];
        ev.sk_rise  = ~ctl_prev[1] & pin_q[1];
        ev.sk_fall  = ctl_prev[1] & ~pin_q[1];
        ev.din      = pin_q[2];
    end

    // storage
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;

    eep_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk   (clk),
        .we    (wr_req & wr_gnt),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    // instruction sequencer
    state_e            state;
    cmd_e              cmd_q;
    logic [CW-1:0]     bitcnt;
    logic [SH_W-2:0]   shreg;
    logic [BW-1:0]     bit_idx;
    logic [SH_W-1:0]   sh_nxt;
    logic [CW-1:0]     cnt_nxt;

    assign sh_nxt  = {shreg, ev.din};
    assign cnt_nxt = bitcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cmd_q      <= CMD_BAD;
            bitcnt     <= '0;
            shreg      <= '0;
            bit_idx    <= IDX_TOP;
            rd_addr    <= '0;
            sdout      <= 1'b0;
            sdout_en   <= 1'b0;
            wr_req     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wen_pulse  <= 1'b0;
            wdis_pulse <= 1'b0;
        end else begin
            wen_pulse  <= 1'b0;
            wdis_pulse <= 1'b0;
            if (state != ST_WREQ && ev.sel_rise) begin
                state    <= ST_IDLE;
                sdout_en <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (ev.sel_fall) begin
                        bitcnt <= '0;
                        if (!ev.sk_lvl) begin
                            state    <= ST_STAT;
                            sdout_en <= 1'b1;
                            sdout    <= ~wr_busy;
                        end else if (wr_busy) begin
                            state <= ST_HOLD;
                        end else begin
                            state <= ST_RECV;
                        end
                    end
                    ST_STAT: begin
                        sdout <= ~wr_busy;
                        if (ev.sk_rise && ev.din) begin
                            sdout_en <= 1'b0;
                            shreg    <= {shreg[SH_W-3:0], 1'b1};
                            bitcnt   <= CW'(1);
                            state    <= wr_busy ? ST_HOLD : ST_RECV;
                        end
                    end
                    ST_RECV: if (ev.sk_rise) begin
                        shreg  <= sh_nxt[SH_W-2:0];
                        bitcnt <= cnt_nxt;
                        if (cnt_nxt == CNT_OP) begin
                            cmd_q <= decode_op(sh_nxt[OP_W-1:0]);
                            if (decode_op(sh_nxt[OP_W-1:0]) == CMD_BAD) state <= ST_HOLD;
                        end else if (cnt_nxt == CNT_HDR) begin
                            case (cmd_q)
                                CMD_READ: begin
                                    state   <= ST_READ;
                                    rd_addr <= sh_nxt[ADDR_W-1:0];
                                    bit_idx <= IDX_TOP;
                                end
                                CMD_WEN: begin
                                    wen_pulse <= 1'b1;
                                    state     <= ST_HOLD;
                                end
                                CMD_WDIS: begin
                                    wdis_pulse <= 1'b1;
                                    state      <= ST_HOLD;
                                end
                                default: ;
                            endcase
                        end else if (cnt_nxt == CNT_FRM) begin
                            wr_req  <= 1'b1;
                            wr_addr <= sh_nxt[DATA_W +: ADDR_W];
                            wr_data <= sh_nxt[DATA_W-1:0];
                            state   <= ST_WREQ;
                        end
                    end
                    ST_READ: if (ev.sk_fall) begin
                        sdout_en <= 1'b1;
                        sdout    <= rd_word[bit_idx];
                        if (bit_idx == '0) begin
                            bit_idx <= IDX_TOP;
                            rd_addr <= rd_addr + 1'b1;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                    ST_WREQ: if (wr_gnt || wr_deny) begin
                        wr_req <= 1'b0;
                        state  <= ev.sel_lvl ? ST_IDLE : ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_front_chk.sv
module eep_front_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_rise,
    input logic              sdout_en,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_gnt,
    input logic              wr_deny,
    input logic              wen_pulse,
    input logic              wdis_pulse
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_gnt && !wr_deny) |=> wr_req);

    p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_gnt && !wr_deny) |=> ($stable(wr_addr) && $stable(wr_data)));

    p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && (wr_gnt || wr_deny)) |=> !wr_req);

    p_cmd_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(wen_pulse && wdis_pulse));

    p_wen_single_r7: assert property (@(posedge clk) disable iff (rst)
        wen_pulse |=> !wen_pulse);

    p_wdis_single_r7: assert property (@(posedge clk) disable iff (rst)
        wdis_pulse |=> !wdis_pulse);

    p_release_z_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && !wr_req) |=> !sdout_en);
endmodule

bind eep_front eep_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_rise   (ev.sel_rise),
    .sdout_en   (sdout_en),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_gnt     (wr_gnt),
    .wr_deny    (wr_deny),
    .wen_pulse  (wen_pulse),
    .wdis_pulse (wdis_pulse)
);

// File: tb/tb_eep_front.sv
`timescale 1ns/1ps
module tb_eep_front;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic wr_gnt = 1'b0, wr_deny = 1'b0, wr_busy = 1'b0;
    logic sdout, sdout_en, wr_req, wen_pulse, wdis_pulse;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;

    always #2.5 clk = ~clk;

    eep_front dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .sdout(sdout), .sdout_en(sdout_en), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt),
        .wr_deny(wr_deny), .wr_busy(wr_busy), .wen_pulse(wen_pulse),
        .wdis_pulse(wdis_pulse)
    );

    int n_cmp = 0, n_bad = 0, settle = 0, n_wen = 0, n_wdis = 0, n_req_rise = 0;
    bit checking = 1'b0, done = 1'b0;
    logic exp_en = 1'b0, exp_do = 1'b0, req_d = 1'b0;
    string cur_tag = "R1";
    logic [15:0] mdl [256];

    // per-clock comparison against the bench's expected pin state
    always @(negedge clk) begin
        if (wen_pulse === 1'b1) n_wen++;
        if (wdis_pulse === 1'b1) n_wdis++;
        if (wr_req === 1'b1 && req_d !== 1'b1) n_req_rise++;
        req_d = wr_req;
        if (checking) begin
            if (settle > 0) settle--;
            else begin
                n_cmp++;
                if (sdout_en !== exp_en || (exp_en && sdout !== exp_do)) begin
                    n_bad++;
                    $display("FAIL %s: sdout_en/sdout = %b/%b expected %b/%b at %0t",
                             cur_tag, sdout_en, sdout, exp_en, exp_do, $time);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic s_n, input logic sk, input logic di,
                         input logic e_en, input logic e_do);
        @(posedge clk); #1;
        sel_n = s_n; sclk = sk; sdin = di;
        exp_en = e_en; exp_do = e_do;
        settle = 5;
        repeat (HOLD) @(posedge clk);
    endtask

    task automatic set_busy(input logic b, input logic e_en, input logic e_do);
        @(posedge clk); #1;
        wr_busy = b; exp_en = e_en; exp_do = e_do; settle = 5;
        repeat (HOLD) @(posedge clk);
    endtask

    task automatic sel_instr();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic desel();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            drive(1'b0, 1'b0, v[i], 1'b0, 1'b0);
            drive(1'b0, 1'b1, v[i], 1'b0, 1'b0);
        end
    endtask

    task automatic read_bits(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] wa;
            logic bv;
            wa = a + 8'(i / 16);
            bv = mdl[wa][15 - (i % 16)];
            drive(1'b0, 1'b0, 1'b0, 1'b1, bv);
            drive(1'b0, 1'b1, 1'b0, 1'b1, bv);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit grant);
        cur_tag = "R2";
        sel_instr();
        send_bits({8'b1010_0100, a, d}, 32);
        check(wr_req === 1'b1, "R2 wr_req after 32 bits", int'(wr_req), 1);
        check(wr_addr === a, "R2 wr_addr", int'(wr_addr), int'(a));
        check(wr_data === d, "R2 wr_data", int'(wr_data), int'(d));
        repeat (4) @(posedge clk);
        check(wr_req === 1'b1 && wr_addr === a, "R10 request held", int'(wr_req), 1);
        #1;
        if (grant) wr_gnt = 1'b1; else wr_deny = 1'b1;
        @(posedge clk); #1;
        wr_gnt = 1'b0; wr_deny = 1'b0;
        @(negedge clk);
        check(wr_req === 1'b0, "R10 request dropped", int'(wr_req), 0);
        if (grant) mdl[a] = d;
        desel();
    endtask

    task automatic do_read(input logic [7:0] a, input int n, input string tag);
        cur_tag = tag;
        sel_instr();
        send_bits({16'h0, 8'b1010_1000, a}, 16);
        read_bits(a, n);
        cur_tag = "R5";
        desel();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        int w0, d0, r0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(sdout_en === 1'b0, "R5 reset sdout_en", int'(sdout_en), 0);
        check(wr_req === 1'b0, "R10 reset wr_req", int'(wr_req), 0);
        checking = 1'b1;

        // writes, granted and denied (R2, R10)
        do_write(8'h10, 16'hBEEF, 1'b1);
        do_write(8'hFF, 16'h1234, 1'b1);
        do_write(8'h00, 16'hC3A5, 1'b1);
        do_write(8'h10, 16'h0000, 1'b0);

        // read after deny still shows granted data (R3, R10)
        do_read(8'h10, 16, "R3");
        // streaming across the top address (R4)
        do_read(8'hFF, 20, "R4");

        // enable / disable commands with arbitrary address (R7)
        cur_tag = "R7";
        w0 = n_wen; d0 = n_wdis;
        sel_instr();
        send_bits({24'h0, 8'b1010_0011}, 8);
        check(n_wen == w0, "R7 no pulse after command byte alone", n_wen - w0, 0);
        send_bits({24'h0, 8'h5A}, 8);
        check(n_wen == w0 + 1, "R7 enable pulse count", n_wen - w0, 1);
        desel();
        sel_instr();
        send_bits({16'h0, 8'b1010_0000, 8'hC3}, 16);
        check(n_wdis == d0 + 1, "R7 disable pulse count", n_wdis - d0, 1);
        check(n_wen == w0 + 1, "R7 no extra enable", n_wen - w0, 1);
        desel();

        // unknown command codes ignored (R8)
        cur_tag = "R8";
        w0 = n_wen; d0 = n_wdis; r0 = n_req_rise;
        sel_instr();
        send_bits({8'b1010_1111, 8'h10, 16'h0F0F}, 32);
        send_bits(32'h0, 4);
        desel();
        sel_instr();
        send_bits({8'hFF, 8'h00, 16'hFFFF}, 32);
        desel();
        check(n_wen == w0 && n_wdis == d0, "R8 no pulses", n_wen + n_wdis, w0 + d0);
        check(n_req_rise == r0, "R8 no write request", n_req_rise, r0);

        // abandoned instructions (R5)
        cur_tag = "R5";
        r0 = n_req_rise;
        sel_instr();
        send_bits({8'b1010_0100, 8'h10, 16'h5555}, 32 - 12);
        desel();
        check(n_req_rise == r0, "R5 aborted write issues no request", n_req_rise, r0);
        cur_tag = "R5";
        sel_instr();
        send_bits({16'h0, 8'b1010_1000, 8'h10}, 16);
        read_bits(8'h10, 6);
        desel();
        do_read(8'h10, 16, "R5");

        // status mode and hand-over (R1, R6)
        cur_tag = "R1";
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        cur_tag = "R6";
        set_busy(1'b1, 1'b1, 1'b0);
        set_busy(1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        send_bits({25'h0, 7'b010_1000}, 7);
        send_bits({24'h0, 8'h00}, 8);
        read_bits(8'h00, 16);
        desel();

        // busy blocks new instructions (R9)
        cur_tag = "R9";
        set_busy(1'b1, 1'b0, 1'b0);
        sel_instr();
        send_bits({16'h0, 8'b1010_1000, 8'h10}, 16);
        send_bits(32'h0, 6);
        desel();
        set_busy(1'b0, 1'b0, 1'b0);
        do_read(8'hFF, 16, "R9");

        repeat (10) @(posedge clk);
        finish_run();
    end
endmodule